// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block works out where an instruction operand lives for a 32-bit processor whose instructions are made of 16-bit words. Decode hands it an 8-bit descriptor. The descriptor carries three fields: the addressing mode, a register number and an operand size. The block reads the data and address register banks through flat input buses. It pulls any extension words it needs, one per handshake, from the instruction-stream fetch port. It then returns a 32-bit address, a register value or an immediate value.

For the post-increment and pre-decrement forms, the block also returns the new address-register value for the register file to write back. It does not touch memory, decode opcodes or compute flags. A descriptor that names no valid form is flagged as illegal.

The controller has four states:
- `S_IDLE` waits for `start`. It goes to `S_DONE` when the descriptor needs no extension word, and to `S_EXT_HI` otherwise.
- `S_EXT_HI` holds `ext_ready` high until a word is accepted. It goes to `S_EXT_LO` for the two-word forms and to `S_DONE` for the others.
- `S_EXT_LO` takes the low half of a two-word value, then goes to `S_DONE`.
- `S_DONE` raises `done` for one cycle, then returns to `S_IDLE`.

Top module: `ea_resolver`

## Requirements
- R1: The descriptor is decoded as mode = bits 7:5, register = bits 4:2 and size = bits 1:0, where size 0 is byte, 1 is word and 2 is long. Register n of each bank sits at bits [32n+31:32n] of its flat bus. After reset, `done`, `ext_ready` and `busy` are low.
- R2: Mode 0 returns data register n, and modes 1 and 2 return address register n. These modes fetch no extension word and raise `done` in the cycle after `start` is accepted.
- R3: Mode 3 returns address register n unchanged. It asserts `wb_en` with `wb_reg` = n and `wb_value` = register + step, where the step is 4 for size 2 and 2 for any other size.
- R4: Mode 4 returns address register n minus the step and writes that same value back through `wb_value`.
- R5: Mode 5 fetches one extension word and returns address register n plus that word sign-extended from 16 bits.
- R6: Mode 6 fetches one index word. The word's bit 15 picks an address register (1) or a data register (0), and bits 14:12 give the register number. If bit 11 is 0, only the low 16 bits of the index register are used, sign-extended. The result is base + index + bits 7:0 of the word sign-extended.
- R7: Mode 7 with register field 0 returns one word sign-extended. Register field 1 returns two words concatenated, with the first word as the high half.
- R8: Mode 7 with register field 2 returns PC + sign-extended word. Register field 3 returns PC + index, formed as in R6. The PC is the `pc_in` value sampled when `start` is accepted.
- R9: Mode 7 with register field 4 returns an immediate. For size 0 it is the zero-extended low byte of one word; for size 1, one zero-extended word; for size 2, two words with the high half first.
- R10: Mode 7 with register field 5, 6 or 7, or register field 4 with size 3, fetches no word. The block finishes with `illegal` high, result 0 and `wb_en` low.
- R11: `ext_ready` stays high until `ext_valid` is seen. Exactly as many words as the form needs are consumed. `done` is a single-cycle pulse.
- R12: While the block is busy, `start` and changes on `desc` and `pc_in` are ignored. The operation in flight completes with its original inputs, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving `desc` (accepted when idle) |
| desc | input | 8 | Mode, register and size descriptor |
| pc_in | input | 32 | Program counter base for PC-relative forms |
| dreg_flat | input | 256 | Eight data registers, register n at [32n+31:32n] |
| areg_flat | input | 256 | Eight address registers, same layout |
| ext_valid | input | 1 | Extension word is present on `ext_word` |
| ext_word | input | 16 | Extension word from the instruction stream |
| ext_ready | output | 1 | Block is waiting for an extension word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| illegal | output | 1 | Descriptor named no valid form |
| result | output | 32 | Resolved address, register value or immediate |
| wb_en | output | 1 | Address register write-back requested |
| wb_reg | output | 3 | Address register to write back |
| wb_value | output | 32 | Write-back value |

## Verification
The bench targets the step size: a design that always adds 4, or that steps a byte by 1, returns wrong write-back values for modes 3 and 4. It also targets the index word's bank select and width bit; a design that ignores either adds the wrong index or the full 32 bits. PC-relative forms are run while `pc_in` changes after `start`, so a design that reads the live PC is caught. Extension words arrive with random stalls, and the bench counts how many are consumed. This exposes a design that samples a word twice, takes too few words for an immediate long, or fetches anything for an illegal descriptor.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EXT_HI = 2'd1,
        S_EXT_LO = 2'd2,
        S_DONE   = 2'd3
    } ea_state_e;

    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;
    localparam int         EXT_W   = 16;
endpackage

// File: rtl/ea_reg_pick.sv
module ea_reg_pick #(
    parameter int W = 32,
    parameter int N = 8,
    localparam int SW = $clog2(N)
) (
    input  logic [W*N-1:0] flat,
    input  logic [SW-1:0]  sel,
    output logic [W-1:0]   word
);
    logic [W-1:0] bank [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign bank[g] = flat[g*W +: W];
    end

    assign word = bank[sel];
endmodule

// File: rtl/ea_brief_index.sv
module ea_brief_index #(
    parameter int W = 32,
    parameter int N = 8,
    localparam int SW = $clog2(N)
) (
    input  logic [W-1:0]   base,
    input  logic           use_addr,
    input  logic [SW-1:0]  idx_num,
    input  logic           idx_long,
    input  logic [7:0]     disp8,
    input  logic [W*N-1:0] dflat,
    input  logic [W*N-1:0] aflat,
    output logic [W-1:0]   sum
);
    logic [W-1:0] idx_raw;
    logic [W-1:0] idx_val;
    logic [W-1:0] disp_ext;

    ea_reg_pick #(.W(W), .N(2*N)) u_pick (
        .flat ({aflat, dflat}),
        .sel  ({use_addr, idx_num}),
        .word (idx_raw)
    );

    always_comb begin
        if (idx_long) idx_val = idx_raw;
        else          idx_val = {{(W-16){idx_raw[15]}}, idx_raw[15:0]};
        disp_ext = {{(W-8){disp8[7]}}, disp8};
        sum      = base + idx_val + disp_ext;
    end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 8,
    localparam int RSEL_W = $clog2(NREG),
    localparam int FLAT_W = ADDR_W * NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        desc,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [FLAT_W-1:0] dreg_flat,
    input  logic [FLAT_W-1:0] areg_flat,
    input  logic              ext_valid,
    input  logic [EXT_W-1:0]  ext_word,
    output logic              ext_ready,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [ADDR_W-1:0] result,
    output logic              wb_en,
    output logic [RSEL_W-1:0] wb_reg,
    output logic [ADDR_W-1:0] wb_value
);
    localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(2);

    ea_state_e state, state_nx;

    logic [7:0]        desc_q;
    logic [ADDR_W-1:0] pc_q, base_q, result_q, wb_val_q;
    logic [EXT_W-1:0]  hi_q;
    logic              wb_en_q, illegal_q;

    logic [2:0] mode_i, mode_q, rf_i, rf_q;
    logic [1:0] sz_i, sz_q;
    assign mode_i = desc[7:5];
    assign rf_i   = desc[4:2];
    assign sz_i   = desc[1:0];
    assign mode_q = desc_q[7:5];
    assign rf_q   = desc_q[4:2];
    assign sz_q   = desc_q[1:0];

    // R1: how many extension words a descriptor consumes
    function automatic logic [1:0] words_for(input logic [7:0] d);
        logic [1:0] n;
        n = 2'd0;
        case (d[7:5])
            3'd5, 3'd6: n = 2'd1;
            3'd7: begin
                case (d[4:2])
                    3'd0, 3'd2, 3'd3: n = 2'd1;
                    3'd1:             n = 2'd2;
                    3'd4: begin
                        if (d[1:0] == SZ_LONG)    n = 2'd2;
                        else if (d[1:0] != SZ_BAD) n = 2'd1;
                    end
                    default: n = 2'd0;
                endcase
            end
            default: n = 2'd0;
        endcase
        return n;
    endfunction

    function automatic logic is_illegal(input logic [7:0] d);
        return (d[7:5] == 3'd7) &&
               ((d[4:2] > 3'd4) || (d[4:2] == 3'd4 && d[1:0] == SZ_BAD));
    endfunction

    // register picks for direct forms (live descriptor)
    logic [ADDR_W-1:0] a_now, d_now;
    ea_reg_pick #(.W(ADDR_W), .N(NREG)) u_apick (
        .flat (areg_flat), .sel (rf_i), .word (a_now));
    ea_reg_pick #(.W(ADDR_W), .N(NREG)) u_dpick (
        .flat (dreg_flat), .sel (rf_i), .word (d_now));

    // index arithmetic shared by mode 6 and PC with index
    logic [ADDR_W-1:0] idx_base, idx_sum;
    assign idx_base = (mode_q == 3'd6) ? base_q : pc_q;
    ea_brief_index #(.W(ADDR_W), .N(NREG)) u_index (
        .base     (idx_base),
        .use_addr (ext_word[15]),
        .idx_num  (ext_word[14:12]),
        .idx_long (ext_word[11]),
        .disp8    (ext_word[7:0]),
        .dflat    (dreg_flat),
        .aflat    (areg_flat),
        .sum      (idx_sum)
    );

    // results for forms with no extension word
    logic [ADDR_W-1:0] step_i, step_q, direct_res, direct_wbv;
    logic              direct_wbe;
    assign step_i = (sz_i == SZ_LONG) ? STEP_LONG : STEP_SHORT;
    assign step_q = (sz_q == SZ_LONG) ? STEP_LONG : STEP_SHORT;

    always_comb begin
        direct_res = '0;
        direct_wbe = 1'b0;
        direct_wbv = '0;
        case (mode_i)
            3'd0: direct_res = d_now;
            3'd1, 3'd2: direct_res = a_now;
            3'd3: begin
                direct_res = a_now;
                direct_wbe = 1'b1;
                direct_wbv = a_now + step_i;
            end
            3'd4: begin
                direct_res = a_now - step_i;
                direct_wbe = 1'b1;
                direct_wbv = a_now - step_i;
            end
            default: direct_res = '0;
        endcase
    end

    // results for single-word forms
    logic [ADDR_W-1:0] sext_word, one_res;
    logic              needs_two;
    assign sext_word = {{(ADDR_W-EXT_W){ext_word[EXT_W-1]}}, ext_word};
    assign needs_two = (words_for(desc_q) == 2'd2);

    always_comb begin
        one_res = '0;
        case (mode_q)
            3'd5: one_res = base_q + sext_word;
            3'd6: one_res = idx_sum;
            3'd7: begin
                case (rf_q)
                    3'd0: one_res = sext_word;
                    3'd2: one_res = pc_q + sext_word;
                    3'd3: one_res = idx_sum;
                    3'd4: one_res = (sz_q == 2'd0) ? ADDR_W'(ext_word[7:0])
                                                   : ADDR_W'(ext_word);
                    default: one_res = '0;
                endcase
            end
            default: one_res = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state and handshake outputs
    always_comb begin
        state_nx  = state;
        ext_ready = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                if (start)
                    state_nx = (words_for(desc) == 2'd0) ? S_DONE : S_EXT_HI;
            end
            S_EXT_HI: begin
                ext_ready = 1'b1;
                if (ext_valid) state_nx = needs_two ? S_EXT_LO : S_DONE;
            end
            S_EXT_LO: begin
                ext_ready = 1'b1;
                if (ext_valid) state_nx = S_DONE;
            end
            S_DONE: begin
                done     = 1'b1;
                state_nx = S_IDLE;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q    <= '0;
            pc_q      <= '0;
            base_q    <= '0;
            hi_q      <= '0;
            result_q  <= '0;
            wb_en_q   <= 1'b0;
            wb_val_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        desc_q    <= desc;
                        pc_q      <= pc_in;
                        base_q    <= a_now;
                        illegal_q <= is_illegal(desc);
                        result_q  <= is_illegal(desc) ? '0 : direct_res;
                        wb_en_q   <= direct_wbe;
                        wb_val_q  <= direct_wbv;
                    end
                end
                S_EXT_HI: begin
                    if (ext_valid) begin
                        hi_q <= ext_word;
                        if (!needs_two) result_q <= one_res;
                    end
                end
                S_EXT_LO: begin
                    if (ext_valid) result_q <= ADDR_W'({hi_q, ext_word});
                end
                S_DONE: begin
                    hi_q <= hi_q;
                end
            endcase
        end
    end

    assign illegal  = illegal_q;
    assign result   = result_q;
    assign wb_en    = wb_en_q;
    assign wb_reg   = rf_q;
    assign wb_value = wb_val_q;

    // ---------------- assertions ----------------
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready && !ext_valid) |=> ext_ready);

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!wb_en && result == '0));

    p_postinc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_en && mode_q == 3'd3) |-> (wb_value - result == step_q));

    p_predec_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_en && mode_q == 3'd4) |-> (wb_value == result));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(desc_q) && $stable(pc_q)));
endmodule

// File: tb/tb_ea_resolver.sv
`timescale 1ns/1ps
module tb_ea_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  desc = '0;
    logic [31:0] pc_in = '0;
    logic [255:0] dflat, aflat;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_ready, busy, done, illegal, wb_en;
    logic [31:0] result, wb_value;
    logic [2:0]  wb_reg;

    logic [31:0] dr [8];
    logic [31:0] ar [8];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always_comb
        for (int i = 0; i < 8; i++) begin
            dflat[i*32 +: 32] = dr[i];
            aflat[i*32 +: 32] = ar[i];
        end

    ea_resolver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc(desc), .pc_in(pc_in),
        .dreg_flat(dflat), .areg_flat(aflat), .ext_valid(ext_valid),
        .ext_word(ext_word), .ext_ready(ext_ready), .busy(busy), .done(done),
        .illegal(illegal), .result(result), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_value(wb_value)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

    function automatic logic [31:0] brief(input logic [31:0] base, input logic [15:0] w);
        logic [31:0] ix;
        ix = w[15] ? ar[w[14:12]] : dr[w[14:12]];
        if (!w[11]) ix = sx16(ix[15:0]);
        return base + ix + {{24{w[7]}}, w[7:0]};
    endfunction

    function automatic void model(input logic [7:0] d, input logic [15:0] w0, w1,
                                  input logic [31:0] pc,
                                  output logic [31:0] res, output logic wbe,
                                  output logic [31:0] wbv, output logic ill,
                                  output int nw);
        logic [2:0] m, r;
        logic [1:0] s;
        logic [31:0] st;
        m = d[7:5]; r = d[4:2]; s = d[1:0];
        st = (s == 2'd2) ? 32'd4 : 32'd2;
        res = 0; wbe = 0; wbv = 0; ill = 0; nw = 0;
        case (m)
            3'd0: res = dr[r];
            3'd1, 3'd2: res = ar[r];
            3'd3: begin res = ar[r]; wbe = 1; wbv = ar[r] + st; end
            3'd4: begin res = ar[r] - st; wbe = 1; wbv = res; end
            3'd5: begin nw = 1; res = ar[r] + sx16(w0); end
            3'd6: begin nw = 1; res = brief(ar[r], w0); end
            default: begin
                case (r)
                    3'd0: begin nw = 1; res = sx16(w0); end
                    3'd1: begin nw = 2; res = {w0, w1}; end
                    3'd2: begin nw = 1; res = pc + sx16(w0); end
                    3'd3: begin nw = 1; res = brief(pc, w0); end
                    3'd4: begin
                        if (s == 2'd0)      begin nw = 1; res = {24'd0, w0[7:0]}; end
                        else if (s == 2'd1) begin nw = 1; res = {16'd0, w0}; end
                        else if (s == 2'd2) begin nw = 2; res = {w0, w1}; end
                        else ill = 1;
                    end
                    default: ill = 1;
                endcase
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] d);
        if (d[7:5] <= 3'd2) return "R2";
        if (d[7:5] == 3'd3) return "R3";
        if (d[7:5] == 3'd4) return "R4";
        if (d[7:5] == 3'd5) return "R5";
        if (d[7:5] == 3'd6) return "R6";
        if (d[4:2] <= 3'd1) return "R7";
        if (d[4:2] <= 3'd3) return "R8";
        if (d[4:2] == 3'd4 && d[1:0] != 2'd3) return "R9";
        return "R10";
    endfunction

    task automatic run_op(input logic [7:0] d, input logic [15:0] w0, w1,
                          input int maxdly, input bit poke);
        logic [31:0] er, ewv;
        logic        ewe, eil;
        int          enw, idx, dly, cyc;
        string       tg;
        model(d, w0, w1, pc_in, er, ewe, ewv, eil, enw);
        tg = tag_of(d);
        @(negedge clk);
        desc = d; start = 1'b1;
        @(negedge clk);
        cyc = 1;
        start = poke;
        pc_in = $urandom;           // R8: live PC must not matter
        if (poke) desc = 8'($urandom); // R12
        idx = 0;
        dly = (maxdly > 0) ? int'($urandom_range(maxdly)) : 0;
        while (!done && cyc < 200) begin
            ext_valid = 1'b0;
            if (ext_ready) begin
                if (dly > 0) dly--;
                else begin
                    ext_valid = 1'b1;
                    ext_word  = (idx == 0) ? w0 : w1;
                    idx++;
                    dly = (maxdly > 0) ? int'($urandom_range(maxdly)) : 0;
                end
            end
            @(negedge clk);
            cyc++;
        end
        ext_valid = 1'b0;
        start = 1'b0;
        chk(done, tg, "done seen", 32'(done), 32'd1);
        chk(result == er, tg, "result", result, er);
        chk(illegal == eil, tg, "illegal", 32'(illegal), 32'(eil));
        chk(wb_en == ewe, tg, "wb_en", 32'(wb_en), 32'(ewe));
        if (ewe) begin
            chk(wb_value == ewv, tg, "wb_value", wb_value, ewv);
            chk(wb_reg == d[4:2], tg, "wb_reg", 32'(wb_reg), 32'(d[4:2]));
        end
        chk(idx == enw, "R11", "words consumed", 32'(idx), 32'(enw));
        if (enw == 0)
            chk(cyc == 1, eil ? "R10" : "R2", "latency", 32'(cyc), 32'd1);
        @(negedge clk);
        chk(!done && !busy, "R12", "idle after done", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic rand_regs();
        for (int i = 0; i < 8; i++) begin
            dr[i] = $urandom;
            ar[i] = $urandom;
        end
        pc_in = $urandom;
    endtask

    function automatic logic [7:0] mk(input int m, input int r, input int s);
        return {3'(m), 3'(r), 2'(s)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rand_regs();
        repeat (3) @(negedge clk);
        chk(!done && !ext_ready && !busy, "R1", "reset outputs",
            {29'd0, done, ext_ready, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !ext_ready && !busy, "R1", "idle after reset",
            {29'd0, done, ext_ready, busy}, 32'd0);

        // directed: direct register forms
        rand_regs();
        run_op(mk(0, 3, 2), 16'h0, 16'h0, 0, 0);  // R2
        run_op(mk(1, 5, 1), 16'h0, 16'h0, 0, 1);  // R2 with poke (R12)
        run_op(mk(2, 7, 0), 16'h0, 16'h0, 0, 0);  // R2
        // step sizes
        ar[2] = 32'h0000_1000;
        run_op(mk(3, 2, 2), 16'h0, 16'h0, 0, 0);  // R3 step 4
        run_op(mk(3, 2, 0), 16'h0, 16'h0, 0, 0);  // R3 byte step 2
        ar[6] = 32'h0000_0002;
        run_op(mk(4, 6, 2), 16'h0, 16'h0, 0, 0);  // R4 wraps below zero
        run_op(mk(4, 6, 1), 16'h0, 16'h0, 0, 0);  // R4 step 2
        // displacement and index
        run_op(mk(5, 1, 1), 16'h8000, 16'h0, 2, 0); // R5 negative disp
        dr[4] = 32'h1234_FFF0;
        run_op(mk(6, 2, 2), 16'h4005, 16'h0, 1, 0); // R6 data reg, short index
        ar[3] = 32'h8000_0010;
        run_op(mk(6, 2, 2), 16'hB8F0, 16'h0, 0, 0); // R6 addr reg, long, neg disp
        // absolute
        run_op(mk(7, 0, 1), 16'hFFFE, 16'h0, 0, 0); // R7 short
        run_op(mk(7, 1, 2), 16'h1234, 16'h5678, 3, 0); // R7 long, stalled
        // PC relative
        run_op(mk(7, 2, 1), 16'hFF00, 16'h0, 2, 1); // R8
        run_op(mk(7, 3, 0), 16'h9880, 16'h0, 1, 0); // R8 index
        // immediates
        run_op(mk(7, 4, 0), 16'hABCD, 16'h0, 0, 0); // R9 byte
        run_op(mk(7, 4, 1), 16'h8001, 16'h0, 0, 0); // R9 word
        run_op(mk(7, 4, 2), 16'hDEAD, 16'hBEEF, 2, 0); // R9 long
        // illegal
        run_op(mk(7, 5, 0), 16'h1111, 16'h2222, 0, 0); // R10
        run_op(mk(7, 7, 3), 16'h1111, 16'h2222, 0, 0); // R10
        run_op(mk(7, 4, 3), 16'h1111, 16'h2222, 0, 0); // R10

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [7:0] d;
            rand_regs();
            d = 8'($urandom);
            if (k % 3 == 0) d[7:5] = 3'd7;
            run_op(d, 16'($urandom), 16'($urandom),
                   int'($urandom_range(3)), bit'($urandom_range(1)));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule